// File: doc/BRIEF.md
# Per-Channel Receive Demultiplexer with Pause Generation

This block sits on a single receive path that delivers one metadata word per packet followed by the packet's payload as 256-bit beats. It reads a three-bit channel index out of the metadata and steers the packet into one of eight per-channel buffers. Each buffer has its own metadata output and payload output, so downstream consumers drain their channels independently.

Every channel keeps a count of the whole packets it holds. When that count reaches a threshold, the block sets the channel's bit in an eight-bit pause vector. When the count falls back below the threshold, it clears the bit. The vector is offered on a valid/ready output only when some bit changes, so a remote sender can stop or restart traffic per priority and nothing is lost.

A packet whose channel has no free slot is not dropped. It holds the shared input until space opens up.

Top module: `pfc_rx_demux`

## Requirements
- R1: A packet's channel is metadata bits [CH_LSB+2:CH_LSB] (default [10:8]). Its metadata word and all of its beats (data, keep, last) appear unchanged only on that channel's outputs; no other channel's out_valid or out_meta_valid rises.
- R2: meta_ready is high only when no packet is in progress and the indexed channel has room. After a metadata handshake, meta_ready stays low and in_ready may be high until the beat with in_last=1 is accepted.
- R3: Packets leave a channel in the order they arrived.
- R4: A channel reserves a slot for each packet from its metadata handshake until its last beat is read, up to BUF_PKTS slots. While the slots are full, a packet for that channel sees meta_ready=0 and waits rather than being dropped. It is accepted after one packet is drained from the channel.
- R5: A channel's stored count rises on the clock edge that writes a last beat and falls on the edge that reads one. Bit i of pause_vec is 1 (pause) while channel i's count is at least THRESH and 0 (resume) otherwise. The bit updates on the same edge as the count.
- R6: pause_valid rises on any edge where pause_vec changes and at no other time. It stays high until pause_ready is seen. A further change while the vector is pending replaces the vector with the newest state.
- R7: A packet's metadata is visible on its channel no later than its first payload beat.
- R8: While out_valid[c] is high and out_ready[c] is low, that channel's data, keep and last hold steady.
- R9: After reset, no output is valid, pause_vec is 0, pause_valid is 0, and meta_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| meta_valid | input | 1 | Metadata word offered |
| meta_ready | output | 1 | Metadata word accepted |
| meta_data | input | MW | Metadata word carrying the channel index |
| in_valid | input | 1 | Payload beat offered |
| in_ready | output | 1 | Payload beat accepted |
| in_data | input | DW | Payload beat |
| in_keep | input | DW/8 | Byte enables of the beat |
| in_last | input | 1 | Final beat of the packet |
| out_meta_valid | output | NCH | Per-channel metadata available |
| out_meta_ready | input | NCH | Per-channel metadata taken |
| out_meta_data | output | NCH*MW | Per-channel metadata words |
| out_valid | output | NCH | Per-channel beat available |
| out_ready | input | NCH | Per-channel beat taken |
| out_data | output | NCH*DW | Per-channel beats |
| out_keep | output | NCH*DW/8 | Per-channel byte enables |
| out_last | output | NCH | Per-channel final-beat flags |
| pause_valid | output | 1 | Pause vector update pending |
| pause_ready | input | 1 | Pause vector update taken |
| pause_vec | output | NCH | Current pause (1) / resume (0) state per channel |

## Verification
The bench fills one channel past its threshold and then to its slot limit. A design that counts beats instead of packets, or that counts at the wrong edge, raises or clears the pause bit at the wrong count. A design that drops the extra packet, or accepts it into a full channel, shows up as a wrong meta_ready while the extra packet waits, and as a missing or overwritten tag when the channel is drained in order. The bench also leaves one pause update unacknowledged while a second channel crosses its threshold, which exposes a design that loses the newer state or re-announces a vector that did not change. Channels with beat counts from one to the maximum catch misrouting and any off-by-one in the buffer pointers.

// File: rtl/pfc_rx_demux.sv
module pfc_rx_demux #(
  parameter int NCH       = 8,
  parameter int DW        = 256,
  parameter int MW        = 32,
  parameter int CH_LSB    = 8,
  parameter int BUF_PKTS  = 4,
  parameter int MAX_BEATS = 4,
  parameter int THRESH    = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  meta_valid,
  output logic                  meta_ready,
  input  logic [MW-1:0]         meta_data,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [DW-1:0]         in_data,
  input  logic [DW/8-1:0]       in_keep,
  input  logic                  in_last,
  output logic [NCH-1:0]        out_meta_valid,
  input  logic [NCH-1:0]        out_meta_ready,
  output logic [NCH*MW-1:0]     out_meta_data,
  output logic [NCH-1:0]        out_valid,
  input  logic [NCH-1:0]        out_ready,
  output logic [NCH*DW-1:0]     out_data,
  output logic [NCH*DW/8-1:0]   out_keep,
  output logic [NCH-1:0]        out_last,
  output logic                  pause_valid,
  input  logic                  pause_ready,
  output logic [NCH-1:0]        pause_vec
);
  localparam int KW  = DW / 8;
  localparam int CW  = $clog2(NCH);
  localparam int BD  = BUF_PKTS * MAX_BEATS;
  localparam int BPW = $clog2(BD);
  localparam int MPW = $clog2(BUF_PKTS);
  localparam int BCW = $clog2(BD + 1);
  localparam int PCW = $clog2(BUF_PKTS + 1);
  localparam int EW  = DW + KW + 1;

  logic          busy;
  logic [CW-1:0] cur_ch;
  logic [NCH-1:0] room, bfree, pz_nxt;

  wire [CW-1:0] req_ch = meta_data[CH_LSB +: CW];

  assign meta_ready = !busy && room[req_ch];
  assign in_ready   = busy && bfree[cur_ch];

  wire meta_fire = meta_valid && meta_ready;
  wire beat_fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      cur_ch <= '0;
    end else if (meta_fire) begin
      busy   <= 1'b1;
      cur_ch <= req_ch;
    end else if (beat_fire && in_last) begin
      busy   <= 1'b0;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [EW-1:0]  bmem [BD];
    logic [MW-1:0]  mmem [BUF_PKTS];
    logic [BPW-1:0] bwp, brp;
    logic [MPW-1:0] mwp, mrp;
    logic [BCW-1:0] bcnt;
    logic [PCW-1:0] mcnt, occ, stored, stored_n;

    wire wr   = beat_fire && (cur_ch == CW'(g));
    wire wl   = wr && in_last;
    wire push = meta_fire && (req_ch == CW'(g));
    wire pop  = out_meta_valid[g] && out_meta_ready[g];
    wire rd   = out_valid[g] && out_ready[g];
    wire rl   = rd && out_last[g];

    assign out_valid[g]      = bcnt != '0;
    assign out_meta_valid[g] = mcnt != '0;
    assign {out_last[g], out_keep[g*KW +: KW], out_data[g*DW +: DW]} = bmem[brp];
    assign out_meta_data[g*MW +: MW] = mmem[mrp];
    assign room[g]   = occ < PCW'(BUF_PKTS);
    assign bfree[g]  = bcnt < BCW'(BD);
    assign stored_n  = stored + PCW'(wl) - PCW'(rl);
    assign pz_nxt[g] = stored_n >= PCW'(THRESH);

    always_ff @(posedge clk) begin
      if (wr)   bmem[bwp] <= {in_last, in_keep, in_data};
      if (push) mmem[mwp] <= meta_data;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        bwp <= '0; brp <= '0; bcnt <= '0;
        mwp <= '0; mrp <= '0; mcnt <= '0;
        occ <= '0; stored <= '0;
      end else begin
        if (wr)   bwp <= (bwp == BPW'(BD - 1)) ? '0 : bwp + 1'b1;
        if (rd)   brp <= (brp == BPW'(BD - 1)) ? '0 : brp + 1'b1;
        if (push) mwp <= (mwp == MPW'(BUF_PKTS - 1)) ? '0 : mwp + 1'b1;
        if (pop)  mrp <= (mrp == MPW'(BUF_PKTS - 1)) ? '0 : mrp + 1'b1;
        bcnt   <= bcnt + BCW'(wr) - BCW'(rd);
        mcnt   <= mcnt + PCW'(push) - PCW'(pop);
        occ    <= occ + PCW'(push) - PCW'(rl);
        stored <= stored_n;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pause_vec   <= '0;
      pause_valid <= 1'b0;
    end else if (pz_nxt != pause_vec) begin
      pause_vec   <= pz_nxt;
      pause_valid <= 1'b1;
    end else if (pause_ready) begin
      pause_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/pfc_rx_demux_chk.sv
module pfc_rx_demux_chk #(
  parameter int NCH = 8,
  parameter int DW  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              meta_valid,
  input logic              meta_ready,
  input logic [NCH-1:0]    out_meta_valid,
  input logic [NCH-1:0]    out_meta_ready,
  input logic [NCH-1:0]    out_valid,
  input logic [NCH-1:0]    out_ready,
  input logic [NCH*DW-1:0] out_data,
  input logic [NCH-1:0]    out_last,
  input logic              pause_valid,
  input logic              pause_ready,
  input logic [NCH-1:0]    pause_vec
);
  assert_reset_state_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!pause_valid && pause_vec == '0 && out_valid == '0 && out_meta_valid == '0));

  assert_one_packet_R2: assert property (@(posedge clk) disable iff (rst)
    (meta_valid && meta_ready) |=> !meta_ready);

  assert_pause_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (pause_valid && !pause_ready) |=> pause_valid);

  assert_pause_announce_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(pause_vec) |-> pause_valid);

  for (genvar c = 0; c < NCH; c++) begin : g_c
    int credit;
    always_ff @(posedge clk) begin
      if (rst) credit <= 0;
      else credit <= credit + ((out_meta_valid[c] && out_meta_ready[c]) ? 1 : 0)
                            - ((out_valid[c] && out_ready[c] && out_last[c]) ? 1 : 0);
    end

    assert_meta_first_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid[c] |-> (out_meta_valid[c] || credit > 0));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
      (out_valid[c] && !out_ready[c]) |=>
        (out_valid[c] && $stable(out_data[c*DW +: DW]) && $stable(out_last[c])));
  end
endmodule

bind pfc_rx_demux pfc_rx_demux_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .meta_valid(meta_valid), .meta_ready(meta_ready),
  .out_meta_valid(out_meta_valid), .out_meta_ready(out_meta_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_last(out_last), .pause_valid(pause_valid), .pause_ready(pause_ready),
  .pause_vec(pause_vec)
);

// File: tb/tb_pfc_rx_demux.sv
module tb_pfc_rx_demux;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8, DW = 256, MW = 32, KW = 32;
  // {channel, beat count}
  localparam logic [5:0] VEC [8] = '{6'o01, 6'o14, 6'o22, 6'o33, 6'o44, 6'o51, 6'o62, 6'o73};

  logic clk = 0, rst = 1;
  logic meta_valid = 0, in_valid = 0, in_last = 0, pause_ready = 0;
  logic [MW-1:0] meta_data = '0;
  logic [DW-1:0] in_data = '0;
  logic [KW-1:0] in_keep = '0;
  logic [NCH-1:0] out_meta_ready = '0, out_ready = '0;
  logic meta_ready, in_ready, pause_valid;
  logic [NCH-1:0] out_meta_valid, out_valid, out_last, pause_vec;
  logic [NCH*MW-1:0] out_meta_data;
  logic [NCH*DW-1:0] out_data;
  logic [NCH*KW-1:0] out_keep;
  int nchk = 0, nfail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfc_rx_demux dut (.*);

  function automatic logic [MW-1:0] mk_meta(input logic [2:0] ch, input logic [7:0] tag);
    return {tag, 8'h5A, 5'd0, ch, 8'h3C};
  endfunction
  function automatic logic [DW-1:0] beat_w(input logic [7:0] tag, input int i);
    return {16{tag, 8'(i)}};
  endfunction
  function automatic logic [KW-1:0] keep_w(input bit last);
    return last ? 32'h0000FFFF : '1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_pkt(input logic [2:0] ch, input logic [7:0] tag, input int nb, input bit chk7);
    @(negedge clk);
    meta_valid = 1; meta_data = mk_meta(ch, tag);
    while (!meta_ready) @(negedge clk);
    @(posedge clk); @(negedge clk);
    meta_valid = 0;
    if (chk7) check(out_meta_valid[ch] && !out_valid[ch], "R7 meta ahead of beats",
                    {out_meta_valid[ch], out_valid[ch]}, 2'b10);
    for (int i = 0; i < nb; i++) begin
      in_valid = 1; in_data = beat_w(tag, i); in_keep = keep_w(i == nb - 1); in_last = (i == nb - 1);
      while (!in_ready) @(negedge clk);
      @(posedge clk); @(negedge clk);
    end
    in_valid = 0; in_last = 0;
  endtask

  task automatic recv_pkt(input logic [2:0] ch, input logic [7:0] tag, input int nb);
    int w = 0;
    while (!out_meta_valid[ch] && w < 50) begin @(negedge clk); w++; end
    check(out_meta_data[ch*MW +: MW] == mk_meta(ch, tag), "R1/R3 metadata",
          out_meta_data[ch*MW +: MW], mk_meta(ch, tag));
    out_meta_ready[ch] = 1; @(posedge clk); @(negedge clk); out_meta_ready[ch] = 0;
    for (int i = 0; i < nb; i++) begin
      w = 0;
      while (!out_valid[ch] && w < 50) begin @(negedge clk); w++; end
      check(out_data[ch*DW +: DW] == beat_w(tag, i), "R1/R3 beat data", out_data[ch*DW +: DW], beat_w(tag, i));
      check(out_keep[ch*KW +: KW] == keep_w(i == nb - 1) && out_last[ch] == (i == nb - 1), "R1 keep/last",
            {out_keep[ch*KW +: KW], out_last[ch]}, {keep_w(i == nb - 1), i == nb - 1});
      out_ready[ch] = 1; @(posedge clk); @(negedge clk); out_ready[ch] = 0;
    end
  endtask

  task automatic ack_pause();
    pause_ready = 1; @(posedge clk); @(negedge clk); pause_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk + 1, nfail);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R9 reset state
    check(out_valid == 0 && out_meta_valid == 0, "R9 outputs idle", {out_valid, out_meta_valid}, 0);
    check(pause_vec == 0 && !pause_valid, "R9 pause idle", {pause_valid, pause_vec}, 0);
    check(meta_ready && !in_ready, "R9 ready", {meta_ready, in_ready}, 2'b10);

    // table: routing across all channels, beat counts 1..4
    for (int i = 0; i < 8; i++) begin
      logic [2:0] ch; int nb;
      ch = VEC[i][5:3]; nb = int'(VEC[i][2:0]);
      send_pkt(ch, 8'h10 + 8'(i), nb, 1'b1);
      check(out_valid == NCH'(1) << ch && out_meta_valid == NCH'(1) << ch, "R1 only target channel",
            {out_valid, out_meta_valid}, {NCH'(1) << ch, NCH'(1) << ch});
      check(pause_vec == 0 && !pause_valid, "R5 single packet below threshold", {pause_valid, pause_vec}, 0);
      recv_pkt(ch, 8'h10 + 8'(i), nb);
    end

    // threshold, capacity, order on channel 2
    send_pkt(3'd2, 8'hA0, 2, 1'b1);
    send_pkt(3'd2, 8'hA1, 3, 1'b0);
    check(pause_vec == 0, "R5 two packets no pause", pause_vec, 0);
    send_pkt(3'd2, 8'hA2, 1, 1'b0);
    check(pause_vec == 8'h04 && pause_valid, "R5/R6 pause at threshold", {pause_valid, pause_vec}, 9'h104);
    ack_pause();
    check(!pause_valid && pause_vec == 8'h04, "R6 ack clears valid", {pause_valid, pause_vec}, 9'h004);
    send_pkt(3'd2, 8'hA3, 4, 1'b0);
    check(!pause_valid && pause_vec == 8'h04, "R6 no change no update", {pause_valid, pause_vec}, 9'h004);
    @(negedge clk);
    meta_valid = 1; meta_data = mk_meta(3'd2, 8'hA4);
    repeat (4) @(negedge clk);
    check(!meta_ready, "R4 full channel stalls input", meta_ready, 0);
    meta_valid = 0;
    held = out_data[2*DW +: DW];
    repeat (3) @(negedge clk);
    check(out_valid[2] && out_data[2*DW +: DW] == held, "R8 stalled beat stable", out_data[2*DW +: DW], held);
    recv_pkt(3'd2, 8'hA0, 2);
    check(meta_ready, "R4 slot freed after drain", meta_ready, 1);
    check(pause_vec == 8'h04 && !pause_valid, "R5 still paused at threshold", {pause_valid, pause_vec}, 9'h004);
    send_pkt(3'd2, 8'hA4, 2, 1'b0);
    recv_pkt(3'd2, 8'hA1, 3);
    check(pause_vec == 8'h04, "R5 paused with count at threshold", pause_vec, 8'h04);
    recv_pkt(3'd2, 8'hA2, 1);
    check(pause_vec == 0 && pause_valid, "R5/R6 resume below threshold", {pause_valid, pause_vec}, 9'h100);
    ack_pause();
    recv_pkt(3'd2, 8'hA3, 4);
    recv_pkt(3'd2, 8'hA4, 2);
    check(out_valid == 0 && out_meta_valid == 0, "R3 channel drained", {out_valid, out_meta_valid}, 0);

    // pending update replaced by newest state
    for (int i = 0; i < 3; i++) send_pkt(3'd5, 8'hC0 + 8'(i), 1, 1'b0);
    check(pause_vec == 8'h20 && pause_valid, "R6 first pause pending", {pause_valid, pause_vec}, 9'h120);
    for (int i = 0; i < 3; i++) send_pkt(3'd6, 8'hD0 + 8'(i), 2, 1'b0);
    check(pause_vec == 8'h60 && pause_valid, "R6 newest vector while pending", {pause_valid, pause_vec}, 9'h160);
    ack_pause();
    check(!pause_valid, "R6 accepted", pause_valid, 0);
    recv_pkt(3'd5, 8'hC0, 1);
    check(pause_vec == 8'h40 && pause_valid, "R5 channels independent", {pause_valid, pause_vec}, 9'h140);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule